// File: doc/BRIEF.md
# Program-ROM Bank Latch with AND-Type Write Conflict

This block switches the program ROM of an 8-bit console cartridge in 32 KiB steps. The CPU sees a 32 KiB window at $8000-$FFFF. Any write in that range stores a 2-bit bank number, and that number drives the two highest program-ROM address lines. The full ROM holds 128 KiB. On the plain board the ROM keeps driving the data bus during a write. The byte that reaches the latch is therefore the CPU byte bitwise-ANDed with the ROM byte at the written address. The `CONFLICT_EN` parameter models this conflict, and clearing it gives a conflict-free variant that latches the CPU byte as written.

The pattern memory on the picture bus is 8 KiB with no banking: it is selected whenever PPU A13 is low, and its address is passed straight through. The nametable mirroring is fixed by a strap pin. Software must not assume a power-on value for the bank, so the bank register has no reset.

The CPU bus is sampled once per clock. A bus cycle is a run of clocks with `cpu_strobe` high, and its address, direction and data are taken from its last clock. A small state machine classifies each clock into one of four states:
- `ST_IDLE`: no strobe.
- `ST_LOW_ACCESS`: strobe with A15 clear.
- `ST_PRG_READ`: strobe, read, A15 set.
- `ST_PRG_WRITE`: strobe, write, A15 set.

Every clock the next state is picked from the inputs alone, so any state can follow any state. The transition that matters is leaving `ST_PRG_WRITE` for any other state: the value captured in the last write clock is committed to the bank register on that edge. Reset forces `ST_IDLE` and takes no commit path, so a write that has not yet been committed is discarded.

Top module: `bnk_prg_latch`

## Requirements
- R1: A write cycle with `cpu_addr[15]`=1 is committed on the first rising edge at which the cycle has ended. The cycle has ended when the strobe is low or the clock is no longer an A15 write. From that edge on, the committed value appears on `prg_addr[16:15]`.
- R2: `prg_addr[14:0]` always equals `cpu_addr[14:0]`.
- R3: With `CONFLICT_EN`=1, the committed bank is `cpu_wdata[1:0] & prg_rdata[1:0]`, both taken in the last clock of the write cycle.
- R4: With `CONFLICT_EN`=0, the committed bank is `cpu_wdata[1:0]`, whatever `prg_rdata` holds.
- R5: The bank keeps its value across reads, across idle clocks, and across writes with `cpu_addr[15]`=0.
- R6: Bits 7..2 of the written byte have no effect on the bank.
- R7: `prg_oe` is 1 exactly when `cpu_strobe`=1, `cpu_rw`=1 (read) and `cpu_addr[15]`=1.
- R8: `chr_addr` equals `ppu_addr[12:0]`. `chr_ce` equals the inverse of `ppu_addr[13]`, and `ciram_ce` equals `ppu_addr[13]`.
- R9: With `mirror_vert`=0, `ciram_a10` follows `ppu_addr[11]`. With `mirror_vert`=1, it follows `ppu_addr[10]`.
- R10: In a write cycle that lasts several clocks, only the address and data of its last clock decide the bank.
- R11: If `rst_n` is low on the edge that would commit a write, the write is discarded and the bank keeps its earlier value.
- R12: A write cycle followed at once by a read strobe, with no idle clock between them, is committed on the first edge of the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of the bus state machine |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_strobe | input | 1 | Bus cycle active |
| prg_rdata | input | 8 | Byte driven by the program ROM at `prg_addr` |
| prg_addr | output | 17 | Program-ROM address: bank on 16..15, window offset below |
| prg_oe | output | 1 | Program-ROM output enable for CPU reads |
| ppu_addr | input | 14 | Picture-bus address |
| mirror_vert | input | 1 | Strap: 1 selects vertical mirroring, 0 selects horizontal |
| chr_addr | output | 13 | Pattern-memory address |
| chr_ce | output | 1 | Pattern-memory select |
| ciram_ce | output | 1 | Nametable RAM select |
| ciram_a10 | output | 1 | Nametable RAM address bit 10 |

## Verification
The bench runs a conflicting instance and a conflict-free instance side by side. It picks ROM bytes whose low bits differ from the written data. A design that ignored the ROM byte, or that ANDed it in the conflict-free variant, would latch the wrong bank.

Long write strobes change their data in the middle of the cycle. A design that committed on the first write clock would keep stale data.

Other cases target a missing commit:
- A write followed at once by a read would leave the bank unchanged if commit waited for an idle clock.
- A reset landing on the commit edge would change the bank if reset failed to cancel the pending write.
- Writes below $8000 and writes with high data bits set would move the bank if decoding or masking were too loose.

// File: rtl/bnk_pkg.sv
package bnk_pkg;

    // Classification of one sampled clock of the CPU bus.
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_PRG_READ   = 2'd1,
        ST_PRG_WRITE  = 2'd2,
        ST_LOW_ACCESS = 2'd3
    } bus_state_t;

    // Picks the state that the present bus inputs describe.
    function automatic bus_state_t classify(input logic strobe,
                                            input logic a15,
                                            input logic rw);
        bus_state_t s;
        if (!strobe)   s = ST_IDLE;
        else if (!a15) s = ST_LOW_ACCESS;
        else if (rw)   s = ST_PRG_READ;
        else           s = ST_PRG_WRITE;
        return s;
    endfunction

endpackage

// File: rtl/bnk_bus_fsm.sv
module bnk_bus_fsm
    import bnk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_strobe,
    input  logic       cpu_a15,
    input  logic       cpu_rw,
    output bus_state_t state_q,
    output logic       capture_en,
    output logic       commit_en
);

    bus_state_t state_d;

    assign state_d = classify(cpu_strobe, cpu_a15, cpu_rw);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: capture while a high write runs, commit when it ends
    always_comb begin
        capture_en = 1'b0;
        commit_en  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PRG_READ, ST_LOW_ACCESS: begin
                capture_en = (state_d == ST_PRG_WRITE);
            end
            ST_PRG_WRITE: begin
                capture_en = (state_d == ST_PRG_WRITE);
                commit_en  = rst_n && (state_d != ST_PRG_WRITE);
            end
            default: begin
                capture_en = 1'b0;
                commit_en  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bnk_bank_latch.sv
module bnk_bank_latch #(
    parameter int BANK_W      = 2,
    parameter bit CONFLICT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              capture_en,
    input  logic              commit_en,
    input  logic [BANK_W-1:0] wdata_lo,
    input  logic [BANK_W-1:0] rdata_lo,
    output logic [BANK_W-1:0] cap_q,
    output logic [BANK_W-1:0] bank_q
);

    logic [BANK_W-1:0] eff_val;

    generate
        if (CONFLICT_EN) begin : g_and_conflict
            assign eff_val = wdata_lo & rdata_lo;
        end else begin : g_clean_write
            logic unused_rdata;
            assign unused_rdata = ^rdata_lo;
            assign eff_val      = wdata_lo;
        end
    endgenerate

    // No reset: the bank has no defined power-on value.
    always_ff @(posedge clk) begin
        if (capture_en) begin
            cap_q <= eff_val;
        end
        if (commit_en) begin
            bank_q <= cap_q;
        end
    end

endmodule

// File: rtl/bnk_ppu_map.sv
module bnk_ppu_map #(
    parameter int PPU_AW = 14,
    parameter int CHR_AW = 13
) (
    input  logic              mirror_vert,
    input  logic [PPU_AW-1:0] ppu_addr,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              chr_ce,
    output logic              ciram_ce,
    output logic              ciram_a10
);

    assign chr_addr  = ppu_addr[CHR_AW-1:0];
    assign chr_ce    = ~ppu_addr[CHR_AW];
    assign ciram_ce  = ppu_addr[CHR_AW];
    assign ciram_a10 = mirror_vert ? ppu_addr[10] : ppu_addr[11];

endmodule

// File: rtl/bnk_prg_latch.sv
module bnk_prg_latch
    import bnk_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int BANK_W      = 2,
    parameter int WIN_W       = 15,
    parameter int PPU_AW      = 14,
    parameter int CHR_AW      = 13,
    parameter bit CONFLICT_EN = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WIN_W:0]          cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    input  logic                    cpu_rw,
    input  logic                    cpu_strobe,
    input  logic [DATA_W-1:0]       prg_rdata,
    output logic [WIN_W+BANK_W-1:0] prg_addr,
    output logic                    prg_oe,
    input  logic [PPU_AW-1:0]       ppu_addr,
    input  logic                    mirror_vert,
    output logic [CHR_AW-1:0]       chr_addr,
    output logic                    chr_ce,
    output logic                    ciram_ce,
    output logic                    ciram_a10
);

    localparam int A15_BIT = WIN_W;

    bus_state_t        state_q;
    logic              capture_en;
    logic              commit_en;
    logic [BANK_W-1:0] cap_q;
    logic [BANK_W-1:0] bank_q;
    logic              unused_hi;

    assign unused_hi = ^{cpu_wdata[DATA_W-1:BANK_W], prg_rdata[DATA_W-1:BANK_W]};

    bnk_bus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_strobe (cpu_strobe),
        .cpu_a15    (cpu_addr[A15_BIT]),
        .cpu_rw     (cpu_rw),
        .state_q    (state_q),
        .capture_en (capture_en),
        .commit_en  (commit_en)
    );

    bnk_bank_latch #(
        .BANK_W      (BANK_W),
        .CONFLICT_EN (CONFLICT_EN)
    ) u_latch (
        .clk        (clk),
        .capture_en (capture_en),
        .commit_en  (commit_en),
        .wdata_lo   (cpu_wdata[BANK_W-1:0]),
        .rdata_lo   (prg_rdata[BANK_W-1:0]),
        .cap_q      (cap_q),
        .bank_q     (bank_q)
    );

    bnk_ppu_map #(
        .PPU_AW (PPU_AW),
        .CHR_AW (CHR_AW)
    ) u_ppu (
        .mirror_vert (mirror_vert),
        .ppu_addr    (ppu_addr),
        .chr_addr    (chr_addr),
        .chr_ce      (chr_ce),
        .ciram_ce    (ciram_ce),
        .ciram_a10   (ciram_a10)
    );

    assign prg_addr = {bank_q, cpu_addr[WIN_W-1:0]};
    assign prg_oe   = cpu_strobe & cpu_rw & cpu_addr[A15_BIT];

endmodule

// File: rtl/bnk_prg_latch_chk.sv
module bnk_prg_latch_chk
    import bnk_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int BANK_W      = 2,
    parameter int WIN_W       = 15,
    parameter bit CONFLICT_EN = 1'b1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [WIN_W:0]          cpu_addr,
    input logic [DATA_W-1:0]       cpu_wdata,
    input logic                    cpu_rw,
    input logic                    cpu_strobe,
    input logic [DATA_W-1:0]       prg_rdata,
    input logic [WIN_W+BANK_W-1:0] prg_addr,
    input logic                    prg_oe,
    input bus_state_t              state_q,
    input logic                    capture_en,
    input logic                    commit_en,
    input logic [BANK_W-1:0]       cap_q
);

    localparam logic [BANK_W-1:0] PASS_MASK = CONFLICT_EN ? '0 : '1;

    // R1
    commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> prg_addr[WIN_W+BANK_W-1:WIN_W] == $past(cap_q));

    // R3
    capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> cap_q == ($past(cpu_wdata[BANK_W-1:0])
                                 & ($past(prg_rdata[BANK_W-1:0]) | PASS_MASK)));

    // R5
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_en |=> $stable(prg_addr[WIN_W+BANK_W-1:WIN_W]));

    // R7
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prg_oe |-> (cpu_rw && cpu_addr[WIN_W] && !capture_en));

    // R12
    write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRG_WRITE && cpu_strobe && cpu_rw) |-> commit_en);

endmodule

bind bnk_prg_latch bnk_prg_latch_chk #(
    .DATA_W      (DATA_W),
    .BANK_W      (BANK_W),
    .WIN_W       (WIN_W),
    .CONFLICT_EN (CONFLICT_EN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rw     (cpu_rw),
    .cpu_strobe (cpu_strobe),
    .prg_rdata  (prg_rdata),
    .prg_addr   (prg_addr),
    .prg_oe     (prg_oe),
    .state_q    (state_q),
    .capture_en (capture_en),
    .commit_en  (commit_en),
    .cap_q      (cap_q)
);

// File: tb/tb_bnk_prg_latch.sv
module tb_bnk_prg_latch;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic [7:0]  cpu_wdata = 8'h0;
    logic        cpu_rw = 1'b1;
    logic        cpu_strobe = 1'b0;
    logic [13:0] ppu_addr = 14'h0;
    logic        mirror_vert = 1'b0;

    logic [7:0]  prg_rdata, prg_rdata_raw;
    logic [16:0] prg_addr, prg_addr_raw;
    logic        prg_oe, prg_oe_raw;
    logic [12:0] chr_addr, chr_addr_raw;
    logic        chr_ce, ciram_ce, ciram_a10;
    logic        chr_ce_raw, ciram_ce_raw, ciram_a10_raw;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    // ROM content model: a fixed hash of the 17-bit address
    function automatic logic [7:0] rom_byte(input logic [16:0] a);
        return a[7:0] ^ {a[16:15], a[13:8]} ^ 8'h5A;
    endfunction

    assign prg_rdata     = rom_byte(prg_addr);
    assign prg_rdata_raw = rom_byte(prg_addr_raw);

    bnk_prg_latch dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rw(cpu_rw), .cpu_strobe(cpu_strobe), .prg_rdata(prg_rdata),
        .prg_addr(prg_addr), .prg_oe(prg_oe), .ppu_addr(ppu_addr),
        .mirror_vert(mirror_vert), .chr_addr(chr_addr), .chr_ce(chr_ce),
        .ciram_ce(ciram_ce), .ciram_a10(ciram_a10)
    );

    bnk_prg_latch #(.CONFLICT_EN(1'b0)) dut_raw (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rw(cpu_rw), .cpu_strobe(cpu_strobe), .prg_rdata(prg_rdata_raw),
        .prg_addr(prg_addr_raw), .prg_oe(prg_oe_raw), .ppu_addr(ppu_addr),
        .mirror_vert(mirror_vert), .chr_addr(chr_addr_raw), .chr_ce(chr_ce_raw),
        .ciram_ce(ciram_ce_raw), .ciram_a10(ciram_a10_raw)
    );

    // Behavioural reference: a pending write and a committed bank per instance
    int m_bank = 0, r_bank = 0;
    bit m_known = 0, r_known = 0;
    bit m_pend = 0, r_pend = 0;
    int m_val = 0, r_val = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend <= 0;
            r_pend <= 0;
        end else if (cpu_strobe && !cpu_rw && cpu_addr[15]) begin
            m_pend <= 1;
            m_val  <= int'(cpu_wdata & prg_rdata) & 3;
            r_pend <= 1;
            r_val  <= int'(cpu_wdata) & 3;
        end else begin
            if (m_pend) begin
                m_bank <= m_val; m_known <= 1; m_pend <= 0;
            end
            if (r_pend) begin
                r_bank <= r_val; r_known <= 1; r_pend <= 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all(input string btag);
        int exp_oe = (cpu_strobe && cpu_rw && cpu_addr[15]) ? 1 : 0;
        int exp_a10 = mirror_vert ? int'(ppu_addr[10]) : int'(ppu_addr[11]);
        chk("R2", int'(prg_addr[14:0]), int'(cpu_addr[14:0]));
        chk("R2", int'(prg_addr_raw[14:0]), int'(cpu_addr[14:0]));
        chk("R7", int'(prg_oe), exp_oe);
        chk("R7", int'(prg_oe_raw), exp_oe);
        chk("R8", int'(chr_addr), int'(ppu_addr[12:0]));
        chk("R8", int'(chr_ce), int'(!ppu_addr[13]));
        chk("R8", int'(ciram_ce), int'(ppu_addr[13]));
        chk("R9", int'(ciram_a10), exp_a10);
        if (m_known) chk(btag, int'(prg_addr[16:15]), m_bank);
        if (r_known) chk({btag, "/R4"}, int'(prg_addr_raw[16:15]), r_bank);
    endtask

    // One bus clock: drive after the falling edge, compare 1 time unit later
    task automatic step(input logic [15:0] a, input logic [7:0] d, input logic rw,
                        input logic stb, input string btag);
        @(negedge clk);
        cpu_addr   = a;
        cpu_wdata  = d;
        cpu_rw     = rw;
        cpu_strobe = stb;
        ppu_addr   = ppu_addr + 14'h0137;
        #1;
        compare_all(btag);
    endtask

    task automatic idle(input int n, input string btag);
        for (int i = 0; i < n; i++) step(16'h0000, 8'h00, 1'b1, 1'b0, btag);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string btag);
        step(a, d, 1'b0, 1'b1, btag);
        step(16'h0000, 8'h00, 1'b1, 1'b0, btag);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // Reset state: no ROM enable while idle (R7)
        idle(3, "R1");
        rst_n = 1'b1;
        idle(2, "R1");

        // R3: conflict ANDs in the ROM byte; R4 instance keeps 3
        wr(16'h8000, 8'hFF, "R3");
        wr(16'h8001, 8'hFF, "R3");
        wr(16'hC0F3, 8'h03, "R3");

        // R5: reads and low writes leave the bank alone
        for (int i = 0; i < 6; i++) step(16'h8000 + 16'(i * 16'h1111), 8'h00, 1'b1, 1'b1, "R5");
        wr(16'h6000, 8'h00, "R5");
        wr(16'h7FFF, 8'h03, "R5");
        wr(16'h0123, 8'h01, "R5");
        idle(2, "R5");

        // R6: high data bits ignored
        wr(16'hFFFF, 8'hFC, "R6");
        wr(16'hA5A5, 8'hF7, "R6");
        wr(16'h9002, 8'h0E, "R6");

        // R10: long write, data changes mid-cycle
        step(16'h8010, 8'h00, 1'b0, 1'b1, "R10");
        step(16'h8010, 8'h00, 1'b0, 1'b1, "R10");
        step(16'hE2C7, 8'hFF, 1'b0, 1'b1, "R10");
        idle(2, "R10");

        // R12: write followed at once by a read strobe
        step(16'hB3B3, 8'h02, 1'b0, 1'b1, "R12");
        step(16'h8004, 8'h00, 1'b1, 1'b1, "R12");
        step(16'h8005, 8'h00, 1'b1, 1'b1, "R12");
        step(16'hD111, 8'h01, 1'b0, 1'b1, "R12");
        step(16'h2000, 8'h00, 1'b1, 1'b1, "R12");
        idle(1, "R12");

        // R11: reset on the commit edge discards the write
        step(16'h8000, 8'h03, 1'b0, 1'b1, "R11");
        @(negedge clk);
        rst_n = 1'b0;
        cpu_strobe = 1'b0;
        #1;
        compare_all("R11");
        idle(2, "R11");
        rst_n = 1'b1;
        idle(3, "R11");

        // R1: sweep addresses and values, with both mirroring straps (R9)
        for (int k = 0; k < 64; k++) begin
            mirror_vert = k[3];
            wr(16'h8000 | 16'(k * 16'h0A13), 8'(k * 7), "R1");
            step(16'h8000 | 16'(k * 16'h0321), 8'h00, 1'b1, 1'b1, "R1");
        end
        for (int k = 0; k < 32; k++) begin
            mirror_vert = k[0];
            idle(1, "R9");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule